// File: doc/BRIEF.md
# Three-Wire Configuration Word Loader

This block lets on-chip control logic program an external frequency synthesizer over a three-wire serial bus: a serial clock, a serial data line and a load strobe. A client hands over one 24-bit configuration word through a valid/ready request port. The block sends the word out most significant bit first. The bits go out as three 8-bit bytes, and a short, parameterized idle stretch of the serial clock sits between the bytes. When the last bit has been clocked, the block raises the load strobe. The rising edge of the strobe tells the peripheral to commit the shifted bits to its target register.

The load strobe stays low for the whole shift. It is raised only after the last bit has been sent, and it is held high for a programmable number of full serial clock periods. The block accepts no new word until the strobe has fallen again. The serial clock is derived from the system clock by a half-period divider. An elaboration check keeps the resulting rate at or below 20 MHz. Two side channels complete the block: a registered power-up output that drives the peripheral's chip-enable pin, and a lock-detect input that passes through a synchronizer and appears as a registered status bit.

Top module: `cfg_word_loader`

## Requirements
- R1: A word offered with `req_valid` high while `req_ready` is high is accepted on that clock edge. The 24 values on `ser_data` sampled at the 24 following rising edges of `ser_clk` equal the word, bit 23 first and bit 0 last.
- R2: `ser_clk` is low when idle. Each high phase lasts HALF_DIV system cycles. Each low phase between bits inside a byte also lasts HALF_DIV cycles. Parameter checks keep SYS_CLK_HZ / (2*HALF_DIV) at or below SCLK_MAX_HZ.
- R3: `ser_data` does not change while `ser_clk` is high. Each new bit appears together with a falling edge of `ser_clk`, or at acceptance for the first bit.
- R4: `ser_load` is low throughout the shift. It rises only after the 24th bit's high phase has ended, with `ser_clk` low and exactly 24 rising clock edges since acceptance.
- R5: The low phase of `ser_clk` between bit 8 and bit 9, and between bit 16 and bit 17, lasts HALF_DIV*(1+BYTE_GAP) system cycles.
- R6: `ser_load` stays high for exactly 2*HALF_DIV*LE_HOLD system cycles. `req_ready` is low from the cycle after acceptance until `ser_load` falls, and it is high again in the cycle in which `ser_load` falls. A request held during the strobe is accepted then.
- R7: A change on `lock_in` appears on `lock_status` after exactly three rising edges of `clk`.
- R8: `chip_en` takes the value of `pwr_up` one clock edge later.
- R9: A synchronous reset, even in the middle of a word, returns `ser_clk`, `ser_load`, `ser_data`, `chip_en` and `lock_status` to 0 and `req_ready` to 1. The next word after the reset is sent complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Configuration word offered |
| req_ready | output | 1 | Block can accept a word |
| req_word | input | 24 | Configuration word to send |
| pwr_up | input | 1 | Requested peripheral power state |
| lock_in | input | 1 | Asynchronous lock-detect from the peripheral |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_load | output | 1 | Load strobe; its rising edge commits the word |
| chip_en | output | 1 | Registered peripheral chip enable |
| lock_status | output | 1 | Synchronized lock-detect status |

## Verification
The timing that matters most is where a new request meets the end of the load strobe. The bench offers the next word as soon as the previous one has been accepted, so `req_valid` is held high for the whole strobe. It then checks that `req_ready` stays low while `ser_load` is high, and that it rises in the very cycle the strobe falls. The word is accepted on that edge with no lost cycle. A toggle on the lock-detect input is also placed in the middle of a shifting word. Its three-edge latency is judged at the ports while the serial bits of that word are still being captured and compared.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2,
      ST_LOAD  = 2'd3
   } cwl_state_e;

   // width of a counter that must hold values 0 .. n-1 (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 2) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/cwl_tick_gen.sv
module cwl_tick_gen #(
   parameter int unsigned HALF_DIV = 7
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic run_i,
   output logic tick_o
);
   localparam int unsigned CW = cwl_pkg::cnt_width(HALF_DIV);
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !run_i)   cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = run_i && (cnt_q == LAST);

   // R2: the half-period counter never leaves its range
   p_div_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= LAST);
endmodule

// File: rtl/cwl_sync.sv
module cwl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i) begin
               if (rst_i) chain_q[0] <= 1'b0;
               else       chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i) begin
               if (rst_i) chain_q[s] <= 1'b0;
               else       chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cwl_shift_engine.sv
module cwl_shift_engine
   import cwl_pkg::*;
#(
   parameter int unsigned WORD_W   = 24,
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned BYTE_GAP = 2,
   parameter int unsigned LE_HOLD  = 1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              tick_i,
   input  logic              req_valid_i,
   input  logic [WORD_W-1:0] req_word_i,
   output logic              req_ready_o,
   output logic              busy_o,
   output logic              ser_clk_o,
   output logic              ser_data_o,
   output logic              ser_load_o
);
   localparam int unsigned IW       = cnt_width(WORD_W);
   localparam logic [IW-1:0] LAST_BIT = IW'(WORD_W - 1);
   localparam int unsigned HOLD_T   = 2 * LE_HOLD;
   localparam int unsigned HW       = cnt_width(HOLD_T);
   localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_T - 1);

   cwl_state_e        state_q;
   logic [WORD_W-1:0] sreg_q;
   logic [IW-1:0]     bit_idx_q;
   logic [HW-1:0]     hold_q;
   logic              sclk_q, sdata_q, load_q;
   logic              byte_end, gap_last, accept;

   assign accept   = (state_q == ST_IDLE) && req_valid_i;
   assign byte_end = ((int'(bit_idx_q) % BYTE_W) == (BYTE_W - 1));

   generate
      if (BYTE_GAP > 0) begin : g_gap
         localparam int unsigned GW = cnt_width(BYTE_GAP);
         localparam logic [GW-1:0] GAP_LAST = GW'(BYTE_GAP - 1);
         logic [GW-1:0] gap_q;
         always_ff @(posedge clk_i) begin
            if (rst_i || state_q != ST_GAP) gap_q <= '0;
            else if (tick_i)                gap_q <= gap_q + 1'b1;
         end
         assign gap_last = (gap_q == GAP_LAST);
      end else begin : g_no_gap
         assign gap_last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q   <= ST_IDLE;
         sreg_q    <= '0;
         bit_idx_q <= '0;
         hold_q    <= '0;
         sclk_q    <= 1'b0;
         sdata_q   <= 1'b0;
         load_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  sreg_q    <= req_word_i;
                  sdata_q   <= req_word_i[WORD_W-1];
                  bit_idx_q <= '0;
                  state_q   <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick_i) begin
                  if (!sclk_q) begin
                     sclk_q <= 1'b1;
                  end else begin
                     sclk_q <= 1'b0;
                     if (bit_idx_q == LAST_BIT) begin
                        load_q  <= 1'b1;
                        hold_q  <= '0;
                        state_q <= ST_LOAD;
                     end else begin
                        bit_idx_q <= bit_idx_q + 1'b1;
                        sreg_q    <= {sreg_q[WORD_W-2:0], 1'b0};
                        sdata_q   <= sreg_q[WORD_W-2];
                        if (BYTE_GAP > 0 && byte_end) state_q <= ST_GAP;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick_i && gap_last) state_q <= ST_SHIFT;
            end
            ST_LOAD: begin
               if (tick_i) begin
                  if (hold_q == HOLD_LAST) begin
                     load_q  <= 1'b0;
                     sdata_q <= 1'b0;
                     state_q <= ST_IDLE;
                  end else begin
                     hold_q <= hold_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign busy_o      = (state_q != ST_IDLE);
   assign ser_clk_o   = sclk_q;
   assign ser_data_o  = sdata_q;
   assign ser_load_o  = load_q;

   // R3: data is held during the high phase of the serial clock
   p_data_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (sclk_q && $past(sclk_q)) |-> $stable(sdata_q));

   // R4: the strobe only rises once the final bit has been clocked
   p_commit_last_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(load_q) |-> (bit_idx_q == LAST_BIT));

   // R4: the serial clock stays low while the strobe is high
   p_load_clk_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      load_q |-> !sclk_q);

   // R6: no acceptance while the strobe is high
   p_busy_load_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      load_q |-> !req_ready_o);

   // R6: ready drops right after a word is taken
   p_ready_drop_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader #(
   parameter longint unsigned SYS_CLK_HZ  = 250_000_000,
   parameter longint unsigned SCLK_MAX_HZ = 20_000_000,
   parameter int unsigned     HALF_DIV    = 7,
   parameter int unsigned     WORD_W      = 24,
   parameter int unsigned     BYTE_W      = 8,
   parameter int unsigned     BYTE_GAP    = 2,
   parameter int unsigned     LE_HOLD     = 1,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [WORD_W-1:0] req_word,
   input  logic              pwr_up,
   input  logic              lock_in,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_load,
   output logic              chip_en,
   output logic              lock_status
);
   localparam longint unsigned SCLK_HZ = SYS_CLK_HZ / (2 * HALF_DIV);

   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("HALF_DIV must be at least 2");
      end
      if (SCLK_HZ > SCLK_MAX_HZ) begin : g_bad_rate
         $error("serial clock rate exceeds SCLK_MAX_HZ");
      end
      if (BYTE_W < 2 || (WORD_W % BYTE_W) != 0) begin : g_bad_byte
         $error("WORD_W must be a multiple of BYTE_W");
      end
      if (LE_HOLD < 1) begin : g_bad_hold
         $error("LE_HOLD must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic tick, busy, lock_sync, lock_q, chip_q;

   cwl_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk_i (clk),
      .rst_i (rst),
      .run_i (busy),
      .tick_o(tick)
   );

   cwl_shift_engine #(
      .WORD_W  (WORD_W),
      .BYTE_W  (BYTE_W),
      .BYTE_GAP(BYTE_GAP),
      .LE_HOLD (LE_HOLD)
   ) u_engine (
      .clk_i      (clk),
      .rst_i      (rst),
      .tick_i     (tick),
      .req_valid_i(req_valid),
      .req_word_i (req_word),
      .req_ready_o(req_ready),
      .busy_o     (busy),
      .ser_clk_o  (ser_clk),
      .ser_data_o (ser_data),
      .ser_load_o (ser_load)
   );

   cwl_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
      .clk_i(clk),
      .rst_i(rst),
      .d_i  (lock_in),
      .q_o  (lock_sync)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         lock_q <= 1'b0;
         chip_q <= 1'b0;
      end else begin
         lock_q <= lock_sync;
         chip_q <= pwr_up;
      end
   end

   assign lock_status = lock_q;
   assign chip_en     = chip_q;

   // R8: chip enable tracks the power request one edge later
   p_chip_follow_r8: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (chip_en == $past(pwr_up)));
endmodule

// File: tb/cfg_word_loader_bench.sv
module cfg_word_loader_bench;
   localparam int HALF = 7;
   localparam int GAP  = 2;
   localparam int HOLD = 1;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [23:0] req_word = '0;
   logic        pwr_up = 1'b0;
   logic        lock_in = 1'b0;
   logic        req_ready, ser_clk, ser_data, ser_load, chip_en, lock_status;

   always #2 clk = ~clk;

   cfg_word_loader #(
      .HALF_DIV(HALF), .BYTE_GAP(GAP), .LE_HOLD(HOLD)
   ) u_cfg_word_loader (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_word(req_word), .pwr_up(pwr_up), .lock_in(lock_in),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
      .chip_en(chip_en), .lock_status(lock_status)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [23:0] exp_mem [64];
   int wr_idx = 0;
   int rd_idx = 0;
   int committed = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // serial bus monitor, sampled between edges
   int nbits = 0, hi_run = 0, lo_run = 0, le_run = 0;
   logic [23:0] shw = '0;
   logic prv_clk = 1'b0, prv_data = 1'b0, prv_le = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         nbits = 0; hi_run = 0; lo_run = 0; le_run = 0; shw = '0;
         prv_clk = 1'b0; prv_data = 1'b0; prv_le = 1'b0;
      end else begin
         if (ser_clk && !prv_clk) begin
            if (nbits > 0) begin
               if (nbits % 8 == 0) chk(lo_run == HALF * (1 + GAP), "R5 byte gap", lo_run, HALF * (1 + GAP));
               else                chk(lo_run == HALF, "R2 low phase", lo_run, HALF);
            end
            shw = {shw[22:0], ser_data};
            nbits++;
            hi_run = 1;
            chk(!ser_load, "R4 load low while shifting", ser_load, 0);
         end else if (ser_clk) begin
            hi_run++;
            chk(ser_data == prv_data, "R3 data stable in high phase", ser_data, prv_data);
         end
         if (!ser_clk && prv_clk) begin
            chk(hi_run == HALF, "R2 high phase", hi_run, HALF);
            lo_run = 1;
         end else if (!ser_clk) begin
            lo_run++;
         end
         if (ser_load && !prv_le) begin
            chk(nbits == 24, "R4 bit count at commit", nbits, 24);
            chk(!ser_clk, "R4 clock low at commit", ser_clk, 0);
            chk(shw == exp_mem[rd_idx % 64], "R1 word content", shw, exp_mem[rd_idx % 64]);
            rd_idx++;
            committed++;
            nbits = 0;
            le_run = 1;
         end else if (ser_load) begin
            le_run++;
            chk(!req_ready, "R6 ready low during strobe", req_ready, 0);
         end
         if (!ser_load && prv_le) begin
            chk(le_run == 2 * HALF * HOLD, "R6 strobe width", le_run, 2 * HALF * HOLD);
            chk(req_ready, "R6 ready returns with strobe fall", req_ready, 1);
         end
         prv_clk = ser_clk; prv_data = ser_data; prv_le = ser_load;
      end
   end

   task automatic send(input logic [23:0] w);
      @(negedge clk);
      exp_mem[wr_idx % 64] = w;
      wr_idx++;
      req_valid = 1'b1;
      req_word  = w;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9 reset state
      chk({ser_clk, ser_load, ser_data, chip_en, lock_status} == 5'b0, "R9 idle outputs", {ser_clk, ser_load, ser_data, chip_en, lock_status}, 0);
      chk(req_ready, "R9 ready after reset", req_ready, 1);

      // R8 chip enable latency
      pwr_up = 1'b1;
      #0 chk(!chip_en, "R8 before edge", chip_en, 0);
      @(negedge clk);
      chk(chip_en, "R8 rise after one edge", chip_en, 1);
      pwr_up = 1'b0;
      @(negedge clk);
      chk(!chip_en, "R8 fall after one edge", chip_en, 0);

      // R1 sweep: corner words and walking ones, back to back (R6 held request)
      send(24'h000000);
      send(24'hFFFFFF);
      send(24'hA5C3F0);
      send(24'h5A3C0F);
      send(24'h800001);
      for (int i = 0; i < 24; i++) send(24'h1 << i);
      wait_idle();
      chk(committed == wr_idx, "R1 words committed", committed, wr_idx);

      // R7 lock toggle while a word is shifting
      fork
         send(24'h3C5A96);
         begin
            repeat (40) @(negedge clk);
            lock_in = 1'b1;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk(!lock_status, "R7 not yet after two edges", lock_status, 0);
            @(negedge clk);
            chk(lock_status, "R7 set after three edges", lock_status, 1);
            lock_in = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk(lock_status, "R7 held after two edges", lock_status, 1);
            @(negedge clk);
            chk(!lock_status, "R7 clear after three edges", lock_status, 0);
         end
      join
      wait_idle();
      lock_in = 1'b1;

      // R9 reset in the middle of a word
      send(24'hDEAD01);
      repeat (100) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk({ser_clk, ser_load, ser_data, lock_status} == 4'b0, "R9 mid-word reset outputs", {ser_clk, ser_load, ser_data, lock_status}, 0);
      chk(req_ready, "R9 ready in reset", req_ready, 1);
      rst = 1'b0;
      lock_in = 1'b0;
      rd_idx = wr_idx;
      committed = 0;
      send(24'h13579B);
      wait_idle();
      chk(committed == 1, "R9 word after reset", committed, 1);

      finish_run();
   end
endmodule